// File: doc/BRIEF.md
# Charge-Domain Multiply Cycle Sequencer

This controller steps a crossbar of charge-storage cells through one binary vector-matrix product. A start strobe captures an N-bit binary input vector. The block then walks a fixed chain of electrode phases. First every column is held at the positive level. The row lines are reset and then left floating. Columns whose captured bit is 1 are pulsed negative, and afterwards all columns are restored to the positive level. The rows are then sampled. Finally the rows are pulsed negative so the charge moves back under the columns. A one-clock done marks the end of the product.

The length of each timed phase comes from its own configuration input. A value of zero counts as one clock. The configuration inputs must stay stable while a product is running. The analog array, the amplifiers and the sample hardware sit outside this block. Only the control waveforms are produced here.

Top module: `chg_mac_seq`

## Requirements
- R1: After reset, and whenever no product is running, every column has only its hold control active, and row_rst, row_float, row_sample, row_return and done are all low.
- R2: The clock after a start is accepted begins the precharge phase. In this phase every column has col_hi set and all row controls are low.
- R3: The row-reset phase follows precharge. In it row_rst is high, row_float is low and all columns are high.
- R4: The float phase follows row reset. In it row_float is high and row_rst is low. row_rst and row_float are never high in the same clock.
- R5: During the pulse phase, column j has col_lo set exactly when bit j of the captured vector is 1, and col_hi set otherwise. row_float stays high.
- R6: The restore phase follows the pulse phase. In it every column is high and row_float stays high.
- R7: The sample phase follows restore. In it row_sample and row_float are high, and every column is high.
- R8: The return phase follows sample. In it row_return is high, row_float is low and every column is high.
- R9: done is high for exactly one clock after the return phase. The block is idle in the next clock.
- R10: Each timed phase lasts the number of clocks on its length input. A length of 0 lasts 1 clock.
- R11: The vector is captured on the accepted start. A start, or a change of in_vec, while a product is running has no effect on the outputs.
- R12: In every clock, each column has exactly one of col_hi, col_lo and col_hold active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a product; accepted only when idle |
| in_vec | input | NCOL | Binary input vector, bit j for column j |
| len_precharge | input | LW | Precharge phase length in clocks |
| len_reset | input | LW | Row-reset phase length |
| len_float | input | LW | Float phase length |
| len_pulse | input | LW | Column pulse phase length |
| len_restore | input | LW | Column restore phase length |
| len_sample | input | LW | Sample phase length |
| len_return | input | LW | Row return phase length |
| col_hi | output | NCOL | Drive column to the positive level |
| col_lo | output | NCOL | Drive column to the negative level |
| col_hold | output | NCOL | Column driver in hold |
| row_rst | output | 1 | Connect rows to the reference level |
| row_float | output | 1 | Rows disconnected and floating |
| row_sample | output | 1 | Sample the row outputs |
| row_return | output | 1 | Pulse rows negative to return the charge |
| done | output | 1 | Product finished, one clock |

## Verification
The hardest case to reach is a second start that arrives in the middle of a product with a different vector. If that start were wrongly accepted, the pulse pattern or the phase timing would change. The stimulus sets start with a new vector on in_vec a few clocks after an accepted start, at a point that lands inside a running product. The bench expects the waveform of the first vector, clock by clock. Zero-length and mixed phase lengths are also applied, so that every phase boundary is checked to the exact clock.

// File: rtl/chg_mac_seq.sv
module chg_mac_seq #(
  parameter int NCOL = 8,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NCOL-1:0] in_vec,
  input  logic [LW-1:0]   len_precharge,
  input  logic [LW-1:0]   len_reset,
  input  logic [LW-1:0]   len_float,
  input  logic [LW-1:0]   len_pulse,
  input  logic [LW-1:0]   len_restore,
  input  logic [LW-1:0]   len_sample,
  input  logic [LW-1:0]   len_return,
  output logic [NCOL-1:0] col_hi,
  output logic [NCOL-1:0] col_lo,
  output logic [NCOL-1:0] col_hold,
  output logic            row_rst,
  output logic            row_float,
  output logic            row_sample,
  output logic            row_return,
  output logic            done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RRST, S_FLT, S_PULSE, S_RESTORE, S_SAMPLE, S_RET, S_DONE
  } phase_t;

  phase_t          st, nxt;
  logic [LW-1:0]   cnt, nxt_len;
  logic [NCOL-1:0] vec_q;

  function automatic logic [LW-1:0] m1(input logic [LW-1:0] l);
    return (l == '0) ? '0 : l - 1'b1;
  endfunction

  always_comb begin
    nxt     = S_IDLE;
    nxt_len = '0;
    case (st)
      S_PRE:     begin nxt = S_RRST;    nxt_len = len_reset;   end
      S_RRST:    begin nxt = S_FLT;     nxt_len = len_float;   end
      S_FLT:     begin nxt = S_PULSE;   nxt_len = len_pulse;   end
      S_PULSE:   begin nxt = S_RESTORE; nxt_len = len_restore; end
      S_RESTORE: begin nxt = S_SAMPLE;  nxt_len = len_sample;  end
      S_SAMPLE:  begin nxt = S_RET;     nxt_len = len_return;  end
      S_RET:     begin nxt = S_DONE;    nxt_len = '0;          end
      default:   begin nxt = S_IDLE;    nxt_len = '0;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      vec_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_PRE;
          cnt   <= m1(len_precharge);
          vec_q <= in_vec;
        end
        S_DONE: st <= S_IDLE;
        default: if (cnt == '0) begin
          st  <= nxt;
          cnt <= m1(nxt_len);
        end else begin
          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign col_hold   = {NCOL{st == S_IDLE}};
  assign col_lo     = (st == S_PULSE) ? vec_q : '0;
  assign col_hi     = ~(col_hold | col_lo);
  assign row_rst    = (st == S_RRST);
  assign row_float  = (st == S_FLT) || (st == S_PULSE) || (st == S_RESTORE) || (st == S_SAMPLE);
  assign row_sample = (st == S_SAMPLE);
  assign row_return = (st == S_RET);
  assign done       = (st == S_DONE);

endmodule

// File: rtl/chg_mac_seq_chk.sv
module chg_mac_seq_chk #(
  parameter int NCOL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCOL-1:0] col_hi,
  input logic [NCOL-1:0] col_lo,
  input logic [NCOL-1:0] col_hold,
  input logic            row_rst,
  input logic            row_float,
  input logic            row_sample,
  input logic            row_return,
  input logic            done
);

  a_r4_rst_float_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_rst && row_float));

  a_r3_float_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_float) |-> $past(row_rst));

  a_r12_col_cover: assert property (@(posedge clk) disable iff (!rst_n)
    ((col_hi | col_lo | col_hold) == {NCOL{1'b1}}) && ((col_hi & col_lo) == '0)
    && ((col_hi & col_hold) == '0) && ((col_lo & col_hold) == '0));

  a_r5_pulse_while_float: assert property (@(posedge clk) disable iff (!rst_n)
    (col_lo != '0) |-> row_float);

  a_r7_sample_cols_high: assert property (@(posedge clk) disable iff (!rst_n)
    row_sample |-> (col_hi == {NCOL{1'b1}}) && row_float);

  a_r8_return_not_float: assert property (@(posedge clk) disable iff (!rst_n)
    row_return |-> !row_float && !row_sample);

  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (col_hold == {NCOL{1'b1}}) && !done);

endmodule

bind chg_mac_seq chg_mac_seq_chk #(.NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_hi(col_hi), .col_lo(col_lo), .col_hold(col_hold),
  .row_rst(row_rst), .row_float(row_float), .row_sample(row_sample),
  .row_return(row_return), .done(done)
);

// File: tb/chg_mac_seq_test.sv
module chg_mac_seq_test;
  localparam int NCOL = 8;
  localparam int LW   = 4;
  localparam int W    = 3*NCOL + 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NCOL-1:0] in_vec = '0;
  logic [LW-1:0] lp = 1, lr = 1, lf = 1, lu = 1, ls = 1, lm = 1, lt = 1;
  logic [NCOL-1:0] col_hi, col_lo, col_hold;
  logic row_rst, row_float, row_sample, row_return, done;

  int checks = 0, fails = 0;
  logic [W-1:0] q[$];
  string tq[$];

  always #10 clk = ~clk;

  chg_mac_seq #(.NCOL(NCOL), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
    .len_precharge(lp), .len_reset(lr), .len_float(lf), .len_pulse(lu),
    .len_restore(ls), .len_sample(lm), .len_return(lt),
    .col_hi(col_hi), .col_lo(col_lo), .col_hold(col_hold),
    .row_rst(row_rst), .row_float(row_float), .row_sample(row_sample),
    .row_return(row_return), .done(done)
  );

  function automatic logic [W-1:0] mk(input logic [NCOL-1:0] h, input logic [NCOL-1:0] l,
      input logic [NCOL-1:0] d, input logic r, input logic f, input logic s,
      input logic t, input logic dn);
    return {h, l, d, r, f, s, t, dn};
  endfunction

  function automatic int eff(input logic [LW-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  wire [W-1:0] obs = {col_hi, col_lo, col_hold, row_rst, row_float, row_sample, row_return, done};

  task automatic compare(input logic [W-1:0] exp, input string tag);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, obs, exp, $time);
    end
  endtask

  task automatic push(input logic [W-1:0] e, input int n, input string tag);
    for (int i = 0; i < n; i++) begin q.push_back(e); tq.push_back(tag); end
  endtask

  task automatic product(input logic [NCOL-1:0] v, input int mid, input logic [NCOL-1:0] v2);
    logic [NCOL-1:0] one = '1;
    @(negedge clk);
    start = 1; in_vec = v;
    push(mk(one, '0, '0, 0, 0, 0, 0, 0), eff(lp), "R2 R10 precharge");
    push(mk(one, '0, '0, 1, 0, 0, 0, 0), eff(lr), "R3 R10 row reset");
    push(mk(one, '0, '0, 0, 1, 0, 0, 0), eff(lf), "R4 R10 float");
    push(mk(~v, v, '0, 0, 1, 0, 0, 0), eff(lu), "R5 R11 pulse");
    push(mk(one, '0, '0, 0, 1, 0, 0, 0), eff(ls), "R6 R10 restore");
    push(mk(one, '0, '0, 0, 1, 1, 0, 0), eff(lm), "R7 R10 sample");
    push(mk(one, '0, '0, 0, 0, 0, 1, 0), eff(lt), "R8 R10 return");
    push(mk(one, '0, '0, 0, 0, 0, 0, 1), 1, "R9 done");
    push(mk('0, '0, one, 0, 0, 0, 0, 0), 1, "R1 R12 idle after");
    @(negedge clk);
    start = 0;
    if (mid > 0) begin
      repeat (mid) @(negedge clk);
      start = 1; in_vec = v2;
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    logic [W-1:0] e;
    string t;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front(); t = tq.pop_front();
        compare(e, t);
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    compare(mk('0, '0, '1, 0, 0, 0, 0, 0), "R1 R12 reset state");

    product(8'hA5, 0, 8'h00);
    product(8'h00, 0, 8'h00);
    product(8'hFF, 0, 8'h00);
    lp = 3; lr = 2; lf = 1; lu = 4; ls = 2; lm = 1; lt = 3;
    product(8'h01, 0, 8'h00);
    product(8'h80, 2, 8'h7E);
    lp = 0; lr = 0; lf = 0; lu = 0; ls = 0; lm = 0; lt = 0;
    product(8'h3C, 1, 8'hC3);
    lp = 2; lr = 5; lf = 3; lu = 2; ls = 1; lm = 2; lt = 1;
    product(8'h5A, 4, 8'hFF);
    product(8'h96, 0, 8'h00);

    @(posedge clk); #5;
    compare(mk('0, '0, '1, 0, 0, 0, 0, 0), "R1 idle at end");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule